// File: doc/BRIEF.md
# SCSI Bus-Master DMA Channel Controller

This block is the register side of one bus-master DMA channel in a SCSI host adapter. Software programs a byte count, a memory address and a descriptor-list address, then writes a command word. A start command copies the programmed values into working registers and enables the SCSI protocol core's DMA path. Idle disables it. Abort sends a cancel pulse to the core. The fourth code, burst flush, is accepted but does nothing.

The memory-side engine asks to move data through a request carrying a length and a direction. The channel refuses any request whose direction disagrees with the command word. An accepted request is clipped to the remaining count, and the working count and address then move by the granted amount. The channel raises a done flag when the count runs out, or when the core reports that its command has completed. A mode input selects how done, abort and error are cleared: either by reading the status word, or by writing ones to it.

Top module: `scsi_dma_chan`

## Requirements
- R1: After a synchronous active-low reset the command, start count, start address and start descriptor words read 0, working count reads 0, working address reads 0xFFFFFFFF, working descriptor reads 0xFFFFFFFD, status reads 0 (with the interrupt input low), and the core DMA enable is low.
- R2: The register words are: 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor, 7 working descriptor. Words 1, 2 and 6 read back as written. The command word keeps bits [7:0], and its upper bits read 0.
- R3: A command write whose bits [1:0] equal 3 (start) has these effects from the next cycle: the working count, address and descriptor hold the start values, status bits [5:0] are 0, and the core DMA enable is high.
- R4: Command code 0 (idle) drives the core DMA enable low. Code 2 (abort) gives a one-cycle cancel pulse and leaves the enable unchanged. Code 1 (burst flush) changes neither output.
- R5: Status bit 4 as read is the live level of the core interrupt input.
- R6: With the clear mode input low, a status read returns the stored flags and then clears done (bit 3), abort (bit 2) and error (bit 1). A status write in this mode has no effect.
- R7: With the clear mode input high, a status read does not clear any flag. A status write clears bits 1, 2 and 3 only where the written value holds a one.
- R8: A transfer request whose direction (1 = device to memory) differs from command bit 7 gives a one-cycle reject pulse. The working count and working address stay unchanged.
- R9: An accepted transfer request gives a one-cycle acknowledge with a grant equal to the smaller of the request length and the working count. The working count falls by the grant and the working address rises by the grant.
- R10: Done (status bit 3) is set when an accepted transfer brings the working count to zero.
- R11: A completion pulse from the core forces the working count to 0 and sets done.
- R12: A write to word 3, 4 or 7 changes nothing and gives a one-cycle invalid-write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers clear-on-read side effects) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| w1c_mode | input | 1 | 1 = flags clear on write-one, 0 = flags clear on read |
| core_int | input | 1 | Interrupt level from the SCSI protocol core |
| core_done | input | 1 | Command-complete pulse from the SCSI protocol core |
| core_dma_en | output | 1 | DMA enable to the SCSI protocol core |
| core_cancel | output | 1 | One-cycle request cancel to the SCSI protocol core |
| xfer_req | input | 1 | Transfer request from the memory engine |
| xfer_dir | input | 1 | Requested direction, 1 = device to memory |
| xfer_len | input | 32 | Requested length in bytes |
| xfer_ack | output | 1 | Transfer accepted pulse |
| xfer_rej | output | 1 | Transfer refused pulse |
| xfer_grant | output | 32 | Granted length, valid with xfer_ack |
| bad_wr | output | 1 | Pulse on a write to a working register |

## Verification
The hardest state to reach from the ports is done being set while the clear mode is write-one-to-clear. The flag is set through the core completion input and never through a register write. The stimulus therefore loads a non-zero count with a start command, pulses the completion input, and switches the mode. It then issues repeated reads and partial-mask writes to show that only a matching one clears the flag. The clip to the remaining count is reached by sending a request longer than the count left after an earlier partial transfer.

// File: rtl/dmac_pkg.sv
// Shared encodings of the DMA channel: register word indices, command codes
// and status bit positions. Assumes 32-bit register words.
package dmac_pkg;
    localparam int DW = 32;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        A_CMD   = 3'd0,
        A_SCNT  = 3'd1,
        A_SADDR = 3'd2,
        A_WCNT  = 3'd3,
        A_WADDR = 3'd4,
        A_STAT  = 3'd5,
        A_SDESC = 3'd6,
        A_WDESC = 3'd7
    } reg_word_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FLUSH = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } dma_op_e;

    localparam int CMD_W       = 8;
    localparam int CMD_DIR_BIT = 7;
    localparam int ST_W        = 6;
    localparam int ST_INT      = 4;
    localparam int ST_DONE     = 3;
    localparam logic [ST_W-1:0] ST_CLR_MASK = 6'b001110;
endpackage

// File: rtl/dmac_xfer_ctr.sv
// Working count and working address of the channel. Loads both on start,
// forces the count to zero on core completion, and otherwise applies
// accepted transfers clipped to the remaining count.
// Priority: load, then force-zero, then transfer. A request that meets
// load or force-zero in the same cycle is refused.
module dmac_xfer_ctr #(
    parameter int DW = 32,
    parameter logic [DW-1:0] ADDR_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ld_count,
    input  logic [DW-1:0] ld_addr,
    input  logic          force_zero,
    input  logic          req,
    input  logic          dir_ok,
    input  logic [DW-1:0] len,
    output logic [DW-1:0] wcount,
    output logic [DW-1:0] waddr,
    output logic          ack,
    output logic          rej,
    output logic [DW-1:0] grant,
    output logic          hit_zero
);
    logic          accept;
    logic [DW-1:0] clip;
    logic [DW-1:0] sum_w;

    // Decide acceptance and the clipped length of the current request.
    always_comb begin
        accept   = req && dir_ok && !load && !force_zero;
        clip     = (len < wcount) ? len : wcount;
        hit_zero = accept && (clip == wcount);
        sum_w    = wcount + waddr;
    end

    // Update working count/address and the handshake pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcount <= '0;
            waddr  <= ADDR_RST;
            ack    <= 1'b0;
            rej    <= 1'b0;
            grant  <= '0;
        end else begin
            ack <= accept;
            rej <= req && !accept;
            if (accept) grant <= clip;
            if (load) begin
                wcount <= ld_count;
                waddr  <= ld_addr;
            end else if (force_zero) begin
                wcount <= '0;
            end else if (accept) begin
                wcount <= wcount - clip;
                waddr  <= waddr + clip;
            end
        end
    end

    AST_REJECT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !dir_ok && !load && !force_zero) |=> ($stable(wcount) && $stable(waddr))); // R8
    AST_SUM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (sum_w == $past(sum_w))); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (wcount <= $past(wcount))); // R9
endmodule

// File: rtl/dmac_status.sv
// Stored status flags of the channel. Start clears all of them. Done is set
// on request, and done/abort/error clear either on read or through a
// write-one mask, as the caller selects. Start takes priority over set.
module dmac_status
    import dmac_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            set_done,
    input  logic            rd_clr,
    input  logic            wr_clr,
    input  logic [ST_W-1:0] wr_bits,
    output logic [ST_W-1:0] stat_q
);
    logic [ST_W-1:0] nxt;

    // Combine the clear sources and the done set into the next flags.
    always_comb begin
        nxt = stat_q;
        if (rd_clr) nxt = nxt & ~ST_CLR_MASK;
        if (wr_clr) nxt = nxt & ~(wr_bits & ST_CLR_MASK);
        if (set_done) nxt[ST_DONE] = 1'b1;
        if (start) nxt = '0;
    end

    // Hold the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= nxt;
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (stat_q == '0)); // R3
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_done && !start) |=> stat_q[ST_DONE]); // R10
endmodule

// File: rtl/scsi_dma_chan.sv
// Register front end of one bus-master DMA channel. Decodes word writes,
// executes the command codes, drives the core enable/cancel, keeps the
// start and descriptor words, and muxes the read data. Assumes one access
// per cycle and read data consumed in the cycle reg_rd is high.
module scsi_dma_chan
    import dmac_pkg::*;
#(
    parameter logic [31:0] WADDR_RST = 32'hFFFF_FFFF,
    parameter logic [31:0] WDESC_RST = 32'hFFFF_FFFD
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        w1c_mode,
    input  logic        core_int,
    input  logic        core_done,
    output logic        core_dma_en,
    output logic        core_cancel,
    input  logic        xfer_req,
    input  logic        xfer_dir,
    input  logic [31:0] xfer_len,
    output logic        xfer_ack,
    output logic        xfer_rej,
    output logic [31:0] xfer_grant,
    output logic        bad_wr
);
    logic [CMD_W-1:0] cmd_q;
    logic [DW-1:0]    scnt_q, saddr_q, sdesc_q, wdesc_q;
    logic [DW-1:0]    wcount, waddr;
    logic [ST_W-1:0]  stat_q;
    logic             cmd_wr, op_start, op_idle, op_abort, ro_wr;
    logic             hit_zero, rd_clr, wr_clr;

    // Decode the write strobe into command operations.
    always_comb begin
        cmd_wr   = reg_wr && (reg_addr == A_CMD);
        op_start = cmd_wr && (reg_wdata[1:0] == OP_START);
        op_idle  = cmd_wr && (reg_wdata[1:0] == OP_IDLE);
        op_abort = cmd_wr && (reg_wdata[1:0] == OP_ABORT);
        ro_wr    = reg_wr && ((reg_addr == A_WCNT) || (reg_addr == A_WADDR)
                              || (reg_addr == A_WDESC));
        rd_clr   = reg_rd && (reg_addr == A_STAT) && !w1c_mode;
        wr_clr   = reg_wr && (reg_addr == A_STAT) && w1c_mode;
    end

    // Programmable words and the working descriptor address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            scnt_q  <= '0;
            saddr_q <= '0;
            sdesc_q <= '0;
            wdesc_q <= WDESC_RST;
        end else begin
            if (cmd_wr) cmd_q <= reg_wdata[CMD_W-1:0];
            if (reg_wr && reg_addr == A_SCNT)  scnt_q  <= reg_wdata;
            if (reg_wr && reg_addr == A_SADDR) saddr_q <= reg_wdata;
            if (reg_wr && reg_addr == A_SDESC) sdesc_q <= reg_wdata;
            if (op_start) wdesc_q <= sdesc_q;
        end
    end

    // Core-side enable level and the cancel / invalid-write pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_dma_en <= 1'b0;
            core_cancel <= 1'b0;
            bad_wr      <= 1'b0;
        end else begin
            if (op_start)     core_dma_en <= 1'b1;
            else if (op_idle) core_dma_en <= 1'b0;
            core_cancel <= op_abort;
            bad_wr      <= ro_wr;
        end
    end

    dmac_xfer_ctr #(.DW(DW), .ADDR_RST(WADDR_RST)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .load(op_start), .ld_count(scnt_q), .ld_addr(saddr_q),
        .force_zero(core_done),
        .req(xfer_req), .dir_ok(xfer_dir == cmd_q[CMD_DIR_BIT]), .len(xfer_len),
        .wcount(wcount), .waddr(waddr),
        .ack(xfer_ack), .rej(xfer_rej), .grant(xfer_grant), .hit_zero(hit_zero)
    );

    dmac_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .start(op_start), .set_done(hit_zero || core_done),
        .rd_clr(rd_clr), .wr_clr(wr_clr), .wr_bits(reg_wdata[ST_W-1:0]),
        .stat_q(stat_q)
    );

    // Read data mux; the interrupt bit comes live from the core.
    always_comb begin
        unique case (reg_addr)
            A_CMD:   reg_rdata = {{(DW-CMD_W){1'b0}}, cmd_q};
            A_SCNT:  reg_rdata = scnt_q;
            A_SADDR: reg_rdata = saddr_q;
            A_WCNT:  reg_rdata = wcount;
            A_WADDR: reg_rdata = waddr;
            A_STAT:  reg_rdata = {{(DW-ST_W){1'b0}}, stat_q | (ST_W'(core_int) << ST_INT)};
            A_SDESC: reg_rdata = sdesc_q;
            default: reg_rdata = wdesc_q;
        endcase
    end

    AST_CANCEL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_cancel |-> $past(op_abort)); // R4
    AST_BADWR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |-> ($past(reg_wr) && $past(reg_addr) inside {3'd3, 3'd4, 3'd7})); // R12
    AST_START_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> core_dma_en); // R3
endmodule

// File: tb/scsi_dma_chan_test.sv
// Directed bench: one task per scenario, each checking its own results.
module scsi_dma_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        w1c_mode = 1'b0, core_int = 1'b0, core_done = 1'b0;
    logic        core_dma_en, core_cancel;
    logic        xfer_req = 1'b0, xfer_dir = 1'b0;
    logic [31:0] xfer_len = '0;
    logic        xfer_ack, xfer_rej, bad_wr;
    logic [31:0] xfer_grant;
    int checks = 0;
    int errors = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    scsi_dma_chan uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic xfer(input logic dir, input logic [31:0] len);
        @(negedge clk);
        xfer_req = 1'b1; xfer_dir = dir; xfer_len = len;
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        core_done = 1'b1;
        @(negedge clk);
        core_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); check("R1 cmd", v, 32'h0);
        rd(3'd1, v); check("R1 scnt", v, 32'h0);
        rd(3'd3, v); check("R1 wcnt", v, 32'h0);
        rd(3'd4, v); check("R1 waddr", v, 32'hFFFF_FFFF);
        rd(3'd5, v); check("R1 stat", v, 32'h0);
        rd(3'd7, v); check("R1 wdesc", v, 32'hFFFF_FFFD);
        check("R1 dma_en", core_dma_en, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(3'd1, 32'h0000_0100);
        wr(3'd2, 32'h8000_0000);
        wr(3'd6, 32'h1234_5670);
        wr(3'd0, 32'hFFFF_FF80);
        rd(3'd0, v); check("R2 cmd low byte only", v, 32'h80);
        rd(3'd1, v); check("R2 scnt", v, 32'h100);
        rd(3'd2, v); check("R2 saddr", v, 32'h8000_0000);
        rd(3'd6, v); check("R2 sdesc", v, 32'h1234_5670);
        check("R4 idle keeps enable low", core_dma_en, 0);
    endtask

    task automatic t_start();
        logic [31:0] v;
        wr(3'd0, 32'h83);
        check("R3 dma_en", core_dma_en, 1);
        rd(3'd3, v); check("R3 wcnt", v, 32'h100);
        rd(3'd4, v); check("R3 waddr", v, 32'h8000_0000);
        rd(3'd7, v); check("R3 wdesc", v, 32'h1234_5670);
        rd(3'd5, v); check("R3 stat", v, 32'h0);
    endtask

    task automatic t_xfer();
        logic [31:0] v;
        xfer(1'b0, 32'h10);
        check("R8 rej", xfer_rej, 1); check("R8 no ack", xfer_ack, 0);
        rd(3'd3, v); check("R8 wcnt", v, 32'h100);
        rd(3'd4, v); check("R8 waddr", v, 32'h8000_0000);
        xfer(1'b1, 32'h40);
        check("R9 ack", xfer_ack, 1); check("R9 grant", xfer_grant, 32'h40);
        rd(3'd3, v); check("R9 wcnt", v, 32'hC0);
        rd(3'd4, v); check("R9 waddr", v, 32'h8000_0040);
        rd(3'd5, v); check("R10 not yet done", v, 32'h0);
        xfer(1'b1, 32'h200);
        check("R9 clipped grant", xfer_grant, 32'hC0);
        rd(3'd3, v); check("R9 wcnt zero", v, 32'h0);
        rd(3'd4, v); check("R9 waddr end", v, 32'h8000_0100);
    endtask

    task automatic t_read_clear();
        logic [31:0] v;
        w1c_mode = 1'b0; core_int = 1'b1;
        rd(3'd5, v); check("R10 done with R5 int", v, 32'h18);
        rd(3'd5, v); check("R6 done cleared by read", v, 32'h10);
        core_int = 1'b0;
        rd(3'd5, v); check("R5 int follows input", v, 32'h0);
        pulse_done();
        wr(3'd5, 32'hFF);
        rd(3'd5, v); check("R6 write ignored", v, 32'h08);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(3'd0, 32'h83);
        rd(3'd3, v); check("R3 reload wcnt", v, 32'h100);
        pulse_done();
        rd(3'd3, v); check("R11 wcnt forced zero", v, 32'h0);
        w1c_mode = 1'b1;
        rd(3'd5, v); check("R11 done set", v, 32'h08);
        rd(3'd5, v); check("R7 read keeps done", v, 32'h08);
        wr(3'd5, 32'h04);
        rd(3'd5, v); check("R7 non-matching mask", v, 32'h08);
        wr(3'd5, 32'h08);
        rd(3'd5, v); check("R7 matching clear", v, 32'h0);
        w1c_mode = 1'b0;
    endtask

    task automatic t_cmds();
        wr(3'd0, 32'h83);
        wr(3'd0, 32'h82);
        check("R4 abort cancel", core_cancel, 1);
        check("R4 abort keeps enable", core_dma_en, 1);
        wr(3'd0, 32'h81);
        check("R4 flush no cancel", core_cancel, 0);
        check("R4 flush keeps enable", core_dma_en, 1);
        wr(3'd0, 32'h80);
        check("R4 idle drops enable", core_dma_en, 0);
    endtask

    task automatic t_badwr();
        logic [31:0] v;
        wr(3'd3, 32'h55);
        check("R12 pulse wcnt", bad_wr, 1);
        rd(3'd3, v); check("R12 wcnt kept", v, 32'h100);
        wr(3'd4, 32'h55);
        check("R12 pulse waddr", bad_wr, 1);
        rd(3'd4, v); check("R12 waddr kept", v, 32'h8000_0000);
        wr(3'd7, 32'h55);
        check("R12 pulse wdesc", bad_wr, 1);
        rd(3'd7, v); check("R12 wdesc kept", v, 32'h1234_5670);
        wr(3'd1, 32'h55);
        check("R12 no pulse on valid write", bad_wr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_start();
        t_xfer();
        t_read_clear();
        t_w1c();
        t_cmds();
        t_badwr();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule